// File: doc/BRIEF.md
# Debug Trigger and Trace Capture Unit

This block sits beside a CPU bus and watches every access for debug events. Two address comparators, A and B, check each bus cycle against a programmed address and, optionally, a read/write direction. A data comparator can qualify comparator A with the bus data. A four-bit mode selects how the comparator results combine into a trigger event: single matches, A-or-B, A-then-B sequencing, data-qualified matches, address ranges, and event-only modes that log bus data on each B match.

A trigger can raise a breakpoint request of one of two kinds. A force breakpoint fires on the matching access itself. A tag breakpoint is taken only on opcode fetches, and fires only once the core reports that the tagged opcode really executed. The same trigger decides what goes into an 8-word, 16-bit capture FIFO. That is either the addresses of change-of-flow cycles after the trigger, or the data of each qualified event. The debug host drains the FIFO through a show-ahead pop port.

The sequencing state machine has five states. OFF holds while disarmed. SEEK is armed and waits for the first event. ARMB means A has been seen and B is awaited (A-then-B modes only). TAGGED means a tag is pending an execute report. TRIG is triggered and sticky. The transitions are:
- OFF→SEEK: when armed.
- SEEK→ARMB: on an A match in a sequential mode.
- SEEK→TRIG or ARMB→TRIG: on a qualified event with force kind.
- SEEK→TAGGED or ARMB→TAGGED: on a qualified event with tag kind.
- TAGGED→TRIG: on an execute strobe with tag valid.
- TAGGED→SEEK or TAGGED→ARMB: on an execute strobe without tag valid. The target is ARMB in sequential modes and SEEK in the others.
- Any state→OFF: when disarmed.

Top module: `dbg_trig_unit`

## Requirements
- R1: While `arm` is low, the unit is disarmed. One cycle later `bkpt_req` is 0, `fifo_empty` is 1, `fifo_count` is 0 and `fifo_ovf` is 0. After reset the same holds.
- R2: A comparator matches when `bus_valid` is 1 and the bus address equals its reference address. If its R/W mask bit is 0, `bus_rnw` must also equal its R/W reference (1 = read). If the mask bit is 1, either direction matches.
- R3: `trig_mode` 0 triggers on an A match. `trig_mode` 1 triggers on an A or a B match. The encodings 9 to 15 never trigger and never capture.
- R4: `trig_mode` 2 (A then B) triggers on a B match only in a cycle after an A match has been seen. A B match before any A match does nothing.
- R5: `trig_mode` 3 triggers on an A match whose `bus_data` equals `b_data`. `trig_mode` 4 triggers on an A match whose `bus_data` differs from `b_data`.
- R6: `trig_mode` 7 triggers when `a_addr` ≤ address ≤ `b_addr`. `trig_mode` 8 triggers when address < `a_addr` or address > `b_addr`. Both modes use A's R/W qualification.
- R7: `trig_mode` 5 stores `bus_data`, zero-extended to 16 bits, on every B match. `trig_mode` 6 does the same, but only after an A match has been seen. In both modes `cap_data_sel` has no effect.
- R8: In the other modes, `cap_data_sel` = 1 stores `bus_data` on each qualified trigger event. `cap_data_sel` = 0 stores `bus_addr` of every `bus_cof` cycle from the cycle after the trigger onward.
- R9: With `force_kind` = 1, the first qualified event moves the unit to TRIG. `bkpt_req` = `bkpt_en` in TRIG, from the next cycle until disarm.
- R10: With `force_kind` = 0, only cycles with `bus_fetch` = 1 can match. A match sets a pending tag. `exec_stb` with `tag_valid` = 1 then sets TRIG. `exec_stb` with `tag_valid` = 0 discards the tag and resumes waiting.
- R11: The FIFO holds 8 entries and returns them oldest first. `fifo_rdata` shows the head while `fifo_empty` is 0. `fifo_pop` removes the head and is ignored when the FIFO is empty.
- R12: A capture that arrives while 8 entries are held is dropped, even if a pop happens in the same cycle. It sets `fifo_ovf`, which stays set until disarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Enables the unit; low clears sequencing and FIFO |
| trig_mode | input | 4 | Trigger mode select |
| cap_data_sel | input | 1 | 1 = capture event data, 0 = change-of-flow addresses |
| force_kind | input | 1 | 1 = force breakpoint, 0 = tag breakpoint |
| bkpt_en | input | 1 | Lets the trigger raise `bkpt_req` |
| a_addr | input | 16 | Comparator A address |
| a_rw | input | 1 | Comparator A direction (1 = read) |
| a_rw_mask | input | 1 | 1 = comparator A ignores direction |
| b_addr | input | 16 | Comparator B address |
| b_data | input | 8 | Data reference for modes 3 and 4 |
| b_rw | input | 1 | Comparator B direction (1 = read) |
| b_rw_mask | input | 1 | 1 = comparator B ignores direction |
| bus_valid | input | 1 | A bus access occurs this cycle |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 8 | Bus data |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_fetch | input | 1 | Access is an opcode fetch |
| bus_cof | input | 1 | Access is a change-of-flow target |
| tag_valid | input | 1 | With `exec_stb`: the tagged opcode executed |
| exec_stb | input | 1 | Execute report for a pending tag |
| fifo_pop | input | 1 | Removes the FIFO head |
| bkpt_req | output | 1 | Breakpoint request |
| fifo_rdata | output | 16 | FIFO head word |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_count | output | 4 | Number of entries held |
| fifo_ovf | output | 1 | A capture was dropped since arming |

## Verification
A wrong sequencing state has two visible effects. `bkpt_req` comes up one cycle too early, or it never comes up; an A-then-B run that triggers on the first B is the typical case. The capture side shows it too: captures appear too soon, or change-of-flow addresses are missing. Both show one cycle after the offending access. A corrupt FIFO pointer or count shows at the pop port as words out of order, lost or duplicated. A wrong full decision shows as a ninth word or a missing overflow flag as soon as the FIFO is drained. Each scenario is therefore judged by the breakpoint level right after each access, and by the full drained FIFO content compared against a queue of expected words.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    localparam logic [3:0] MODE_A          = 4'd0;
    localparam logic [3:0] MODE_A_OR_B     = 4'd1;
    localparam logic [3:0] MODE_A_THEN_B   = 4'd2;
    localparam logic [3:0] MODE_A_BDATA    = 4'd3;
    localparam logic [3:0] MODE_A_NOT_BDAT = 4'd4;
    localparam logic [3:0] MODE_EVT_B      = 4'd5;
    localparam logic [3:0] MODE_A_EVT_B    = 4'd6;
    localparam logic [3:0] MODE_INSIDE     = 4'd7;
    localparam logic [3:0] MODE_OUTSIDE    = 4'd8;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SEEK,
        ST_ARMB,
        ST_TAGGED,
        ST_TRIG
    } trig_state_t;

    function automatic logic mode_is_seq(input logic [3:0] m);
        return (m == MODE_A_THEN_B) || (m == MODE_A_EVT_B);
    endfunction

    function automatic logic mode_is_evt(input logic [3:0] m);
        return (m == MODE_EVT_B) || (m == MODE_A_EVT_B);
    endfunction

endpackage

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rnw,
    input  logic [AW-1:0] ref_addr,
    input  logic          ref_rw,
    input  logic          rw_mask,
    output logic          addr_eq,
    output logic          addr_lt,
    output logic          rw_ok
);
    always_comb begin
        addr_eq = (bus_addr == ref_addr);
        addr_lt = (bus_addr < ref_addr);
        rw_ok   = rw_mask || (bus_rnw == ref_rw);
    end
endmodule

// File: rtl/dbg_trig_fsm.sv
module dbg_trig_fsm
    import dbg_trig_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic [3:0]  trig_mode,
    input  logic        force_kind,
    input  logic        bus_valid,
    input  logic        bus_fetch,
    input  logic        exec_stb,
    input  logic        tag_valid,
    input  logic [1:0]  cmp_eq,
    input  logic [1:0]  cmp_lt,
    input  logic [1:0]  cmp_rw_ok,
    input  logic        bdata_eq,
    output trig_state_t state,
    output logic        qev,
    output logic        hit_a
);
    trig_state_t nxt;
    logic        qual;
    logic        hit_b;
    logic        in_range;
    logic        out_range;
    logic        cond;
    logic        in_win;
    logic        seq;

    // Access qualification shared by all modes
    always_comb begin
        seq       = mode_is_seq(trig_mode);
        qual      = bus_valid && (force_kind || bus_fetch);
        hit_a     = qual && cmp_eq[0] && cmp_rw_ok[0];
        hit_b     = qual && cmp_eq[1] && cmp_rw_ok[1];
        in_range  = qual && cmp_rw_ok[0] && !cmp_lt[0] && (cmp_lt[1] || cmp_eq[1]);
        out_range = qual && cmp_rw_ok[0] && (cmp_lt[0] || (!cmp_lt[1] && !cmp_eq[1]));
    end

    // Output process: qualified trigger event
    always_comb begin
        case (trig_mode)
            MODE_A:          cond = hit_a;
            MODE_A_OR_B:     cond = hit_a || hit_b;
            MODE_A_THEN_B:   cond = hit_b;
            MODE_A_BDATA:    cond = hit_a && bdata_eq;
            MODE_A_NOT_BDAT: cond = hit_a && !bdata_eq;
            MODE_EVT_B:      cond = hit_b;
            MODE_A_EVT_B:    cond = hit_b;
            MODE_INSIDE:     cond = in_range;
            MODE_OUTSIDE:    cond = out_range;
            default:         cond = 1'b0;
        endcase
        if (seq) begin
            in_win = (state == ST_ARMB) || (state == ST_TAGGED) || (state == ST_TRIG);
        end else begin
            in_win = (state != ST_OFF);
        end
        qev = cond && in_win;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!arm) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:    nxt = ST_SEEK;
                ST_SEEK: begin
                    if (seq) begin
                        if (hit_a) nxt = ST_ARMB;
                    end else if (qev) begin
                        nxt = force_kind ? ST_TRIG : ST_TAGGED;
                    end
                end
                ST_ARMB: begin
                    if (qev) nxt = force_kind ? ST_TRIG : ST_TAGGED;
                end
                ST_TAGGED: begin
                    if (exec_stb) begin
                        if (tag_valid) nxt = ST_TRIG;
                        else           nxt = seq ? ST_ARMB : ST_SEEK;
                    end
                end
                ST_TRIG:   nxt = ST_TRIG;
                default:   nxt = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    AST_DISARM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> state == ST_OFF); // R1

    AST_SEQ_NEEDS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEEK && seq) |=> (state == ST_SEEK || state == ST_ARMB || state == ST_OFF)); // R4

    AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIG && arm) |=> state == ST_TRIG); // R9

    AST_TAG_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAGGED && arm && !exec_stb) |=> state == ST_TAGGED); // R10

    AST_TAG_FETCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEEK && !force_kind && !bus_fetch) |=> state != ST_TAGGED); // R10

endmodule

// File: rtl/dbg_cap_fifo.sv
module dbg_cap_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic          ovf
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          full;
    logic          do_push;
    logic          do_pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        rdata   = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push && full) ovf <= 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R12

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !clr) |=> (ovf && count == CW'(DEPTH) - CW'($past(pop)))); // R12

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> empty); // R11

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !ovf)); // R1

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
    import dbg_trig_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [3:0]    trig_mode,
    input  logic          cap_data_sel,
    input  logic          force_kind,
    input  logic          bkpt_en,
    input  logic [AW-1:0] a_addr,
    input  logic          a_rw,
    input  logic          a_rw_mask,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_data,
    input  logic          b_rw,
    input  logic          b_rw_mask,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_rnw,
    input  logic          bus_fetch,
    input  logic          bus_cof,
    input  logic          tag_valid,
    input  logic          exec_stb,
    input  logic          fifo_pop,
    output logic          bkpt_req,
    output logic [AW-1:0] fifo_rdata,
    output logic          fifo_empty,
    output logic [CW-1:0] fifo_count,
    output logic          fifo_ovf
);
    localparam int NCMP = 2;

    logic [AW-1:0] ref_addr [NCMP];
    logic [NCMP-1:0] ref_rw;
    logic [NCMP-1:0] ref_mask;
    logic [NCMP-1:0] cmp_eq;
    logic [NCMP-1:0] cmp_lt;
    logic [NCMP-1:0] cmp_rw_ok;
    logic            bdata_eq;
    trig_state_t     state;
    logic            qev;
    logic            hit_a;
    logic            push_data;
    logic            push_cof;
    logic            push;
    logic [AW-1:0]   wdata;

    always_comb begin
        ref_addr[0] = a_addr;
        ref_addr[1] = b_addr;
        ref_rw      = {b_rw, a_rw};
        ref_mask    = {b_rw_mask, a_rw_mask};
        bdata_eq    = (bus_data == b_data);
    end

    for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
        dbg_addr_cmp #(.AW(AW)) u_cmp (
            .bus_addr (bus_addr),
            .bus_rnw  (bus_rnw),
            .ref_addr (ref_addr[gi]),
            .ref_rw   (ref_rw[gi]),
            .rw_mask  (ref_mask[gi]),
            .addr_eq  (cmp_eq[gi]),
            .addr_lt  (cmp_lt[gi]),
            .rw_ok    (cmp_rw_ok[gi])
        );
    end

    dbg_trig_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .trig_mode  (trig_mode),
        .force_kind (force_kind),
        .bus_valid  (bus_valid),
        .bus_fetch  (bus_fetch),
        .exec_stb   (exec_stb),
        .tag_valid  (tag_valid),
        .cmp_eq     (cmp_eq),
        .cmp_lt     (cmp_lt),
        .cmp_rw_ok  (cmp_rw_ok),
        .bdata_eq   (bdata_eq),
        .state      (state),
        .qev        (qev),
        .hit_a      (hit_a)
    );

    // Capture selection
    always_comb begin
        push_data = qev && (mode_is_evt(trig_mode) || cap_data_sel);
        push_cof  = !mode_is_evt(trig_mode) && !cap_data_sel &&
                    (state == ST_TRIG) && bus_valid && bus_cof;
        push      = push_data || push_cof;
        wdata     = push_data ? AW'(bus_data) : bus_addr;
        bkpt_req  = bkpt_en && arm && (state == ST_TRIG);
    end

    dbg_cap_fifo #(.W(AW), .DEPTH(FIFO_DEPTH), .CW(CW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!arm),
        .push  (push),
        .wdata (wdata),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .count (fifo_count),
        .ovf   (fifo_ovf)
    );

    AST_SEQ_ARMB_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEEK && mode_is_seq(trig_mode) && arm && !hit_a) |=> state != ST_ARMB); // R4

    AST_EVT_IGNORES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && mode_is_evt(trig_mode) && bus_valid && bus_cof && !qev && !fifo_pop && !fifo_empty)
        |=> $stable(fifo_count)); // R7

endmodule

// File: tb/sim_dbg_trig_unit.sv
module sim_dbg_trig_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [3:0]  trig_mode = '0;
    logic        cap_data_sel = 1'b0;
    logic        force_kind = 1'b1;
    logic        bkpt_en = 1'b1;
    logic [15:0] a_addr = '0;
    logic        a_rw = 1'b0;
    logic        a_rw_mask = 1'b1;
    logic [15:0] b_addr = '0;
    logic [7:0]  b_data = '0;
    logic        b_rw = 1'b0;
    logic        b_rw_mask = 1'b1;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        bus_rnw = 1'b1;
    logic        bus_fetch = 1'b0;
    logic        bus_cof = 1'b0;
    logic        tag_valid = 1'b0;
    logic        exec_stb = 1'b0;
    logic        fifo_pop = 1'b0;
    logic        bkpt_req;
    logic [15:0] fifo_rdata;
    logic        fifo_empty;
    logic [3:0]  fifo_count;
    logic        fifo_ovf;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_trig_unit u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [3:0] m, input logic cs, input logic fk,
                         input logic [15:0] aa, input logic [15:0] ba, input logic [7:0] bd,
                         input logic am, input logic arw);
        arm = 1'b0;
        @(negedge clk);
        trig_mode = m; cap_data_sel = cs; force_kind = fk;
        a_addr = aa; b_addr = ba; b_data = bd; a_rw_mask = am; a_rw = arw;
        arm = 1'b1;
        @(negedge clk);
        exp_q.delete();
    endtask

    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rnw,
                       input logic fetch, input logic cof);
        bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_rnw = rnw;
        bus_fetch = fetch; bus_cof = cof;
        @(negedge clk);
        bus_valid = 1'b0; bus_fetch = 1'b0; bus_cof = 1'b0;
    endtask

    task automatic exec(input logic tv);
        exec_stb = 1'b1; tag_valid = tv;
        @(negedge clk);
        exec_stb = 1'b0; tag_valid = 1'b0;
    endtask

    // Monitor: pops the FIFO and compares each word against the scoreboard
    task automatic drain(input string req);
        while (!fifo_empty) begin
            if (exp_q.size() == 0) begin
                chk(req, {16'h0, fifo_rdata}, 32'hDEAD_BEEF);
            end else begin
                chk(req, {16'h0, fifo_rdata}, {16'h0, exp_q.pop_front()});
            end
            fifo_pop = 1'b1;
            @(negedge clk);
            fifo_pop = 1'b0;
        end
        chk(req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset bkpt", bkpt_req, 0);
        chk("R1 reset empty", fifo_empty, 1);
        chk("R1 reset count", fifo_count, 0);
        chk("R1 reset ovf", fifo_ovf, 0);

        // R7 mode 5, capture select ignored
        setup(4'd5, 1'b0, 1'b1, 16'h1000, 16'h2000, 8'h00, 1'b1, 1'b0);
        bus(16'h2000, 8'h11, 1, 0, 1); exp_q.push_back(16'h0011);
        bus(16'h1000, 8'h22, 1, 0, 1);
        bus(16'h2000, 8'h33, 0, 0, 1); exp_q.push_back(16'h0033);
        chk("R9 force bkpt mode5", bkpt_req, 1);
        drain("R7 event-only B");

        // R2 + R8 mode 0, direction qualified, change-of-flow capture
        setup(4'd0, 1'b0, 1'b1, 16'h1234, 16'h0000, 8'h00, 1'b0, 1'b1);
        bus(16'h1234, 8'h01, 0, 0, 0);
        chk("R2 write ignored by read comparator", bkpt_req, 0);
        chk("R8 no capture before trigger", fifo_empty, 1);
        bus(16'h1234, 8'h02, 1, 0, 0);
        chk("R2 read matches", bkpt_req, 1);
        bus(16'h0400, 8'h00, 1, 0, 1); exp_q.push_back(16'h0400);
        bus(16'h0500, 8'h00, 1, 0, 0);
        bus(16'h0600, 8'h00, 1, 0, 1); exp_q.push_back(16'h0600);
        drain("R8 change-of-flow capture");

        // R2 mask
        setup(4'd0, 1'b0, 1'b1, 16'h1234, 16'h0000, 8'h00, 1'b1, 1'b1);
        bus(16'h1234, 8'h01, 0, 0, 0);
        chk("R2 masked direction matches write", bkpt_req, 1);

        // R3 mode 1
        setup(4'd1, 1'b1, 1'b1, 16'h1000, 16'h2000, 8'h00, 1'b1, 1'b0);
        bus(16'h3000, 8'h07, 1, 0, 0);
        chk("R3 A-or-B idle", bkpt_req, 0);
        bus(16'h2000, 8'h09, 1, 0, 0); exp_q.push_back(16'h0009);
        chk("R3 A-or-B via B", bkpt_req, 1);
        drain("R8 data capture mode1");

        // R4 mode 2
        setup(4'd2, 1'b1, 1'b1, 16'h1000, 16'h2000, 8'h00, 1'b1, 1'b0);
        bus(16'h2000, 8'hB1, 1, 0, 0);
        chk("R4 B before A ignored", bkpt_req, 0);
        chk("R4 B before A no capture", fifo_empty, 1);
        bus(16'h1000, 8'hA1, 1, 0, 0);
        chk("R4 A alone no trigger", bkpt_req, 0);
        bus(16'h2000, 8'hB2, 1, 0, 0); exp_q.push_back(16'h00B2);
        chk("R4 B after A triggers", bkpt_req, 1);
        drain("R4 capture");

        // R5 modes 3 and 4
        setup(4'd3, 1'b1, 1'b1, 16'h1000, 16'h0000, 8'h5A, 1'b1, 1'b0);
        bus(16'h1000, 8'h00, 1, 0, 0);
        bus(16'h1001, 8'h5A, 1, 0, 0);
        chk("R5 A-and-Bdata no match", bkpt_req, 0);
        bus(16'h1000, 8'h5A, 1, 0, 0); exp_q.push_back(16'h005A);
        chk("R5 A-and-Bdata match", bkpt_req, 1);
        drain("R5 mode3 capture");
        setup(4'd4, 1'b1, 1'b1, 16'h1000, 16'h0000, 8'h5A, 1'b1, 1'b0);
        bus(16'h1000, 8'h5A, 1, 0, 0);
        chk("R5 A-not-Bdata no match", bkpt_req, 0);
        bus(16'h1000, 8'h11, 1, 0, 0); exp_q.push_back(16'h0011);
        drain("R5 mode4 capture");

        // R6 ranges
        setup(4'd7, 1'b1, 1'b1, 16'h0100, 16'h01FF, 8'h00, 1'b1, 1'b0);
        bus(16'h00FF, 8'h01, 1, 0, 0);
        bus(16'h0100, 8'h02, 1, 0, 0); exp_q.push_back(16'h0002);
        bus(16'h01FF, 8'h03, 1, 0, 0); exp_q.push_back(16'h0003);
        bus(16'h0200, 8'h04, 1, 0, 0);
        drain("R6 inside range");
        setup(4'd8, 1'b1, 1'b1, 16'h0100, 16'h01FF, 8'h00, 1'b1, 1'b0);
        bus(16'h00FF, 8'h01, 1, 0, 0); exp_q.push_back(16'h0001);
        bus(16'h0150, 8'h02, 1, 0, 0);
        bus(16'h0200, 8'h04, 1, 0, 0); exp_q.push_back(16'h0004);
        drain("R6 outside range");

        // R7 mode 6
        setup(4'd6, 1'b0, 1'b1, 16'h1000, 16'h2000, 8'h00, 1'b1, 1'b0);
        bus(16'h2000, 8'h01, 1, 0, 1);
        bus(16'h1000, 8'h02, 1, 0, 1);
        bus(16'h2000, 8'h03, 1, 0, 1); exp_q.push_back(16'h0003);
        bus(16'h2000, 8'h04, 1, 0, 1); exp_q.push_back(16'h0004);
        drain("R7 A then event-only B");

        // R10 tag breakpoint
        setup(4'd0, 1'b0, 1'b0, 16'h0800, 16'h0000, 8'h00, 1'b1, 1'b0);
        bus(16'h0800, 8'h00, 1, 0, 0);
        exec(1'b1);
        chk("R10 non-fetch access not tagged", bkpt_req, 0);
        bus(16'h0800, 8'h00, 1, 1, 0);
        chk("R10 tag pending no bkpt", bkpt_req, 0);
        exec(1'b0);
        chk("R10 flushed tag no bkpt", bkpt_req, 0);
        bus(16'h0800, 8'h00, 1, 1, 0);
        exec(1'b1);
        chk("R10 executed tag fires", bkpt_req, 1);

        // R9 enable gating, sticky
        bkpt_en = 1'b0;
        setup(4'd0, 1'b0, 1'b1, 16'h0900, 16'h0000, 8'h00, 1'b1, 1'b0);
        bus(16'h0900, 8'h00, 1, 0, 0);
        chk("R9 gated by bkpt_en", bkpt_req, 0);
        bkpt_en = 1'b1;
        #1;
        chk("R9 sticky trigger", bkpt_req, 1);

        // R3 unused encoding
        setup(4'd12, 1'b1, 1'b1, 16'h1000, 16'h2000, 8'h00, 1'b1, 1'b0);
        bus(16'h1000, 8'h01, 1, 0, 0);
        bus(16'h2000, 8'h02, 1, 0, 0);
        chk("R3 unused mode no bkpt", bkpt_req, 0);
        chk("R3 unused mode no capture", fifo_empty, 1);

        // R11/R12 overflow
        setup(4'd5, 1'b1, 1'b1, 16'h1000, 16'h2000, 8'h00, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) begin
            bus(16'h2000, 8'(8'h40 + i), 1, 0, 0);
            if (i < 8) exp_q.push_back(16'(8'h40 + i));
        end
        chk("R12 count saturates", fifo_count, 8);
        chk("R12 overflow set", fifo_ovf, 1);
        drain("R11 order after overflow");
        chk("R12 overflow sticky", fifo_ovf, 1);
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
        chk("R11 pop on empty ignored", fifo_count, 0);
        arm = 1'b0;
        @(negedge clk);
        chk("R1 disarm clears ovf", fifo_ovf, 0);
        chk("R1 disarm empty", fifo_empty, 1);
        chk("R1 disarm bkpt", bkpt_req, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule